// File: doc/BRIEF.md
# Bus slot aligner

The block drives the active-low WAIT input of an 8-bit processor that shares its RAM with a video controller. A free-running phase counter cuts time into slots of four clocks. A CPU bus cycle may finish only when the slot reaches its grant phase. The other phases of every slot belong to display fetch and RAM refresh. The block watches the memory-request, I/O-request and M1 strobes of the processor. It holds WAIT low until the pending cycle can finish on the grant phase. So a bus cycle gets a variable number of wait states, not a fixed count. Every cycle's end is pushed onto the four-clock grid.

A plain I/O cycle (I/O request with M1 high) needs one more full pass through the grant phase before it is released. This extra padding sits on top of the grid alignment. An interrupt-acknowledge cycle (I/O request with M1 low) is only aligned. The current phase is exported on `slot_phase` so that the video side can schedule its own fetches. Idle clocks and internal-operation clocks, where no strobe is active, never see WAIT.

WAIT is computed from the strobes and the phase at each rising clock edge, and it is registered there. The value the CPU samples on a falling edge is therefore always stable.

Top module: `bus_slot_aligner`

## Requirements
- R1: While `rst_n` is low, `slot_phase` is 0 and `wait_n` is 1.
- R2: After reset, `slot_phase` advances by one at each rising clock edge, modulo 4, whatever the strobes do.
- R3: When neither `mreq_n` nor `iorq_n` is low at a rising edge, `wait_n` is 1 after that edge.
- R4: A memory cycle (`mreq_n` low, `iorq_n` high) sampled at a rising edge leaves `wait_n` = 1 after that edge only if `slot_phase` becomes 0 there; otherwise `wait_n` = 0. A CPU that releases its strobe on the first falling edge where its minimum length is met and `wait_n` is 1 therefore always ends the cycle at `slot_phase` 0.
- R5: A memory cycle of minimum length L that starts at phase p lasts the smallest n >= L with (p+n) mod 4 = 0. A 4,3,4 sequence that starts at phase 0 totals 12 clocks.
- R6: A 4-clock fetch followed by 2 internal clocks, repeated back to back from phase 0, costs 8 clocks per repetition after the first.
- R7: An I/O cycle (`iorq_n` low, `m1_n` high) is held until the slot phase has reached 0 twice while its strobe is active. A 4,4,4 sequence ending in an I/O cycle, started at phase 0, totals 16 clocks.
- R8: An interrupt-acknowledge cycle (`iorq_n` low, `m1_n` low) gets alignment only, with the same length as a memory cycle from the same phase.
- R9: An I/O cycle of minimum length 4 that starts at phase p ends at phase 0 after the smallest n >= 4 with (p+n) mod 4 = 0 that covers at least two arrivals at phase 0.
- R10: `wait_n` changes only at rising clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mreq_n | input | 1 | Active-low memory-request strobe from the CPU |
| iorq_n | input | 1 | Active-low I/O-request strobe from the CPU |
| m1_n | input | 1 | Active-low M1 strobe; low together with `iorq_n` marks an acknowledge |
| wait_n | output | 1 | Active-low WAIT to the CPU, registered |
| slot_phase | output | PHASE_W | Current phase within the four-clock slot, for the video side |

## Verification
The bench uses the default parameters: a two-bit phase, grant phase 0 and one padding pass for I/O. With these values every start phase of every cycle kind is reached in a few clocks. It drives memory, I/O and acknowledge cycles from each of the four phases. A per-clock reference then checks phase, WAIT and WAIT stability through the full slot. It also exercises the second grant crossing that I/O needs, and the 4,3,4, 4,4,4-with-I/O and repeated 6-clock instruction sequences that show the grid's effect on whole instructions.

// File: rtl/slot_pkg.sv
package slot_pkg;
  typedef enum logic [1:0] {
    REQ_NONE = 2'd0,
    REQ_MEM  = 2'd1,
    REQ_IO   = 2'd2,
    REQ_ACK  = 2'd3
  } req_kind_e;
endpackage

// File: rtl/slot_phase_ctr.sv
module slot_phase_ctr #(
  parameter int PHASE_W     = 2,
  parameter int GRANT_PHASE = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic [PHASE_W-1:0] phase,
  output logic               at_grant
);
  localparam logic [PHASE_W-1:0] GRANT_V = PHASE_W'(GRANT_PHASE);

  logic [PHASE_W-1:0] phase_q;
  logic [PHASE_W-1:0] phase_nxt;

  assign phase_nxt = PHASE_W'(phase_q + 1'b1);
  assign at_grant  = (phase_nxt == GRANT_V);
  assign phase     = phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_nxt;
  end

  // phase steps by one every clock, wrapping
  assert_phase_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (phase_q == PHASE_W'($past(phase_q) + 1'b1)));
endmodule

// File: rtl/req_classify.sv
module req_classify
  import slot_pkg::*;
(
  input  logic      mreq_n,
  input  logic      iorq_n,
  input  logic      m1_n,
  output req_kind_e kind
);
  always_comb begin
    if (!iorq_n)      kind = m1_n ? REQ_IO : REQ_ACK;
    else if (!mreq_n) kind = REQ_MEM;
    else              kind = REQ_NONE;
  end
endmodule

// File: rtl/io_pad_tracker.sv
module io_pad_tracker #(
  parameter int IO_PAD_SLOTS = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic is_io,
  input  logic at_grant,
  output logic pad_done
);
  generate
    if (IO_PAD_SLOTS == 0) begin : g_nopad
      assign pad_done = 1'b1;
    end else begin : g_pad
      localparam int CNT_W = $clog2(IO_PAD_SLOTS + 1);
      localparam logic [CNT_W-1:0] LIMIT = CNT_W'(IO_PAD_SLOTS);
      logic [CNT_W-1:0] cnt_q;

      assign pad_done = (cnt_q == LIMIT);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     cnt_q <= '0;
        else if (!is_io)                cnt_q <= '0;
        else if (at_grant && !pad_done) cnt_q <= CNT_W'(cnt_q + 1'b1);
      end

      // padding count restarts once the I/O strobe is gone
      assert_pad_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !is_io |=> (cnt_q == '0));
    end
  endgenerate
endmodule

// File: rtl/wait_gen.sv
module wait_gen
  import slot_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  req_kind_e kind,
  input  logic      at_grant,
  input  logic      pad_done,
  output logic      wait_n
);
  logic hold;
  logic wait_q;

  always_comb begin
    hold = 1'b0;
    if (kind != REQ_NONE) begin
      hold = !at_grant;
      if (kind == REQ_IO && !pad_done) hold = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wait_q <= 1'b1;
    else        wait_q <= !hold;
  end

  assign wait_n = wait_q;

  assert_idle_no_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == REQ_NONE) |=> wait_n);
  assert_mem_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == REQ_MEM && !at_grant) |=> !wait_n);
  assert_mem_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == REQ_MEM && at_grant) |=> wait_n);
  assert_io_pad_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == REQ_IO && !pad_done) |=> !wait_n);
  assert_ack_align_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == REQ_ACK && at_grant) |=> wait_n);
endmodule

// File: rtl/bus_slot_aligner.sv
module bus_slot_aligner
  import slot_pkg::*;
#(
  parameter int PHASE_W      = 2,
  parameter int GRANT_PHASE  = 0,
  parameter int IO_PAD_SLOTS = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mreq_n,
  input  logic               iorq_n,
  input  logic               m1_n,
  output logic               wait_n,
  output logic [PHASE_W-1:0] slot_phase
);
  localparam logic [PHASE_W-1:0] GRANT_V = PHASE_W'(GRANT_PHASE);

  req_kind_e kind;
  logic      at_grant;
  logic      pad_done;
  logic      is_io;

  assign is_io = (kind == REQ_IO);

  slot_phase_ctr #(.PHASE_W(PHASE_W), .GRANT_PHASE(GRANT_PHASE)) u_phase (
    .clk(clk), .rst_n(rst_n), .phase(slot_phase), .at_grant(at_grant));

  req_classify u_class (
    .mreq_n(mreq_n), .iorq_n(iorq_n), .m1_n(m1_n), .kind(kind));

  io_pad_tracker #(.IO_PAD_SLOTS(IO_PAD_SLOTS)) u_pad (
    .clk(clk), .rst_n(rst_n), .is_io(is_io), .at_grant(at_grant), .pad_done(pad_done));

  wait_gen u_wait (
    .clk(clk), .rst_n(rst_n), .kind(kind), .at_grant(at_grant),
    .pad_done(pad_done), .wait_n(wait_n));

  // WAIT low on the grant phase only for plain I/O padding
  assert_grant_only_io_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wait_n && slot_phase == GRANT_V) |-> $past(is_io));
endmodule

// File: tb/bus_slot_aligner_bench.sv
`timescale 1ns/1ps
module bus_slot_aligner_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mreq_n = 1'b1;
  logic iorq_n = 1'b1;
  logic m1_n = 1'b1;
  logic wait_n;
  logic [1:0] slot_phase;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  bus_slot_aligner u_bus_slot_aligner (
    .clk(clk), .rst_n(rst_n), .mreq_n(mreq_n), .iorq_n(iorq_n),
    .m1_n(m1_n), .wait_n(wait_n), .slot_phase(slot_phase));

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural reference, evaluated every clock
  int  m_phase = 0;
  int  m_cross = 0;
  bit  exp_wait = 1;
  bit  s_mem, s_any, s_io;
  int  s_nxt;
  always begin
    @(posedge clk);
    if (!rst_n) begin
      m_phase = 0; m_cross = 0; exp_wait = 1;
    end else begin
      s_mem = !mreq_n;
      s_any = !iorq_n;
      s_io  = s_any && m1_n;
      s_nxt = (m_phase + 1) % 4;
      if (s_io && s_nxt == 0) m_cross++;
      if (!s_io) m_cross = 0;
      if (!(s_mem || s_any))      exp_wait = 1;
      else if (s_nxt != 0)        exp_wait = 0;
      else if (s_io && m_cross < 2) exp_wait = 0;
      else                        exp_wait = 1;
      m_phase = s_nxt;
    end
    #1;
    if (!finished) begin
      chk(slot_phase == m_phase, rst_n ? "R2 phase" : "R1 phase", slot_phase, m_phase);
      chk(wait_n == exp_wait, rst_n ? "R4 wait" : "R1 wait", wait_n, exp_wait);
    end
    #2;
    if (!finished) chk(wait_n == exp_wait, "R10 wait stable", wait_n, exp_wait);
  end

  function automatic int exp_len(int p, int minlen, int need);
    int n = minlen;
    forever begin
      int cr = 0;
      for (int k = 1; k <= n; k++) if ((p + k) % 4 == 0) cr++;
      if ((p + n) % 4 == 0 && cr >= need) return n;
      n++;
    end
  endfunction

  task automatic align_to(int p);
    while (slot_phase != 2'(p)) @(negedge clk);
  endtask

  // kind: 0 mem, 1 fetch, 2 io, 3 ack; called at a falling edge
  task automatic bus(int kind, int minlen, string req, output int len);
    mreq_n = !(kind == 0 || kind == 1);
    iorq_n = !(kind == 2 || kind == 3);
    m1_n   = !(kind == 1 || kind == 3);
    len = 0;
    do begin
      @(negedge clk);
      len++;
    end while (!(len >= minlen && wait_n));
    chk(slot_phase == 0, req, slot_phase, 0);
    mreq_n = 1; iorq_n = 1; m1_n = 1;
  endtask

  initial begin
    int l, l2, l3, sum;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R3: idle clocks never see WAIT
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(wait_n == 1, "R3 idle", wait_n, 1);
    end
    for (int p = 0; p < 4; p++) begin
      align_to(p);
      bus(0, 4, "R4 mem end phase", l);
      chk(l == exp_len(p, 4, 1), "R5 mem length", l, exp_len(p, 4, 1));
      align_to(p);
      bus(2, 4, "R9 io end phase", l);
      chk(l == exp_len(p, 4, 2), "R9 io length", l, exp_len(p, 4, 2));
      align_to(p);
      bus(3, 4, "R8 ack end phase", l);
      chk(l == exp_len(p, 4, 1), "R8 ack length", l, exp_len(p, 4, 1));
      align_to(p);
      bus(0, 3, "R5 short end phase", l);
      chk(l == exp_len(p, 3, 1), "R5 short length", l, exp_len(p, 3, 1));
    end
    // R5: 4,3,4 sequence
    align_to(0);
    bus(1, 4, "R5 seq", l);  sum = l;
    bus(0, 3, "R5 seq", l);  sum += l;
    bus(0, 4, "R5 seq", l);  sum += l;
    chk(sum == 12, "R5 4,3,4 total", sum, 12);
    // R7: 4,4,4 ending in I/O write
    align_to(0);
    bus(1, 4, "R7 seq", l);  sum = l;
    bus(0, 4, "R7 seq", l);  sum += l;
    bus(2, 4, "R7 seq", l);  sum += l;
    chk(sum == 16, "R7 4,4,4 io total", sum, 16);
    // R6: repeated fetch plus two internal clocks
    align_to(0);
    bus(1, 4, "R6 fetch", l);
    repeat (2) @(negedge clk);
    chk(l + 2 == 6, "R6 first instruction", l + 2, 6);
    bus(1, 4, "R6 fetch", l2);
    repeat (2) @(negedge clk);
    chk(l2 + 2 == 8, "R6 second instruction", l2 + 2, 8);
    bus(1, 4, "R6 fetch", l3);
    repeat (2) @(negedge clk);
    chk(l3 + 2 == 8, "R6 third instruction", l3 + 2, 8);
    repeat (4) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule